// File: doc/BRIEF.md
# I/O Port Permission Checker

This block rules on whether a port input or output instruction may go ahead or must trap. A request carries the current privilege level of the running code, the global I/O privilege threshold, the 16-bit port number and the length, in bits, of the active task's per-port permission bitmap. A request whose current level does not exceed the threshold is granted without touching the bitmap. Any other request is first checked against the bitmap length. A port past the end of the bitmap traps at once. A port inside the bitmap causes a single word read from bitmap storage, and the port's bit in that word decides the outcome.

Bitmap storage sits outside the block and behaves as a synchronous read port. The block raises a one-cycle read strobe with a word address and then waits for a read-valid pulse, for any number of cycles. Requests and results each use a valid/ready handshake. The block takes one request at a time and holds its result until the consumer accepts it.

Top module: `io_perm_check`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready_o` is 1 and `rsp_valid_o` and `mem_rd_en_o` are 0.
- R2: When a request with `req_cpl_i <= req_iopl_i` is accepted, `rsp_valid_o` is 1 in the next cycle with `rsp_allow_o`=1 and `rsp_reason_o`=0, and no bitmap read is issued.
- R3: When a request with `req_cpl_i > req_iopl_i` and `req_port_i >= req_map_len_i` is accepted, `rsp_valid_o` is 1 in the next cycle with `rsp_allow_o`=0 and `rsp_reason_o`=1 (beyond bitmap), and no bitmap read is issued. A length of 0 makes every such port trap.
- R4: When a request with `req_cpl_i > req_iopl_i` and `req_port_i < req_map_len_i` is accepted, `mem_rd_en_o` is 1 for exactly one cycle, in the next cycle, with `mem_rd_addr_o` equal to the port divided by 16.
- R5: The result of a bitmap lookup appears in the cycle after the one in which `mem_rd_valid_i` is 1. If bit (port mod 16) of `mem_rd_data_i` is 1, the result is allow with reason 0. If that bit is 0, the result is trap with reason 2 (bit clear). Until then `rsp_valid_o` stays 0.
- R6: `req_ready_o` is 1 only when no request is in flight. A request presented while the block is busy is not taken, and it does not alter the result in flight.
- R7: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the result holds steady. After the handshake completes, `rsp_valid_o` is 0 and `req_ready_o` is 1 in the next cycle.
- R8: `rsp_reason_o` is 0 exactly when `rsp_allow_o` is 1, whenever `rsp_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_cpl_i | input | 2 | Current privilege level of the code |
| req_iopl_i | input | 2 | Global I/O privilege threshold |
| req_port_i | input | 16 | I/O port number |
| req_map_len_i | input | 17 | Bitmap length in bits (0 to 65536) |
| mem_rd_en_o | output | 1 | Bitmap read strobe, one cycle |
| mem_rd_addr_o | output | 12 | Bitmap word address |
| mem_rd_valid_i | input | 1 | Bitmap read data valid |
| mem_rd_data_i | input | 16 | Bitmap read data word |
| rsp_valid_o | output | 1 | Result present |
| rsp_ready_i | input | 1 | Result consumer ready |
| rsp_allow_o | output | 1 | 1 = access allowed, 0 = trap |
| rsp_reason_o | output | 2 | 0 none, 1 beyond bitmap, 2 port bit clear |

## Verification
A granted-by-threshold or beyond-bitmap result is due in the cycle after acceptance. A bitmap read strobe is due in the cycle after acceptance, and a lookup result is due one cycle after the read-valid pulse. The bench's memory model returns data after a random latency of 1 to 4 cycles. The bench samples at falling edges. It checks that the result is still absent in every cycle before the read-valid pulse and present in the cycle just after. During back-pressure it checks that the result stays put, and a strobe counter confirms that the fast paths never read the bitmap.

// File: rtl/iop_pkg.sv
package iop_pkg;

  typedef enum logic [1:0] {
    TR_NONE      = 2'd0,
    TR_BEYOND    = 2'd1,
    TR_BIT_CLEAR = 2'd2
  } trap_why_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_RESP
  } iop_state_e;

  typedef struct packed {
    logic      allow;
    trap_why_e why;
  } verdict_t;

endpackage

// File: rtl/iop_screen.sv
// Threshold and length screening, purely combinational
module iop_screen #(
  parameter int PL_W   = 2,
  parameter int PORT_W = 16,
  localparam int LEN_W = PORT_W + 1
) (
  input  logic [PL_W-1:0]   cpl_i,
  input  logic [PL_W-1:0]   iopl_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [LEN_W-1:0]  map_len_i,
  output logic              grant_fast_o,
  output logic              beyond_o
);
  assign grant_fast_o = (cpl_i <= iopl_i);
  assign beyond_o     = ({1'b0, port_i} >= map_len_i);
endmodule

// File: rtl/iop_bit_pick.sv
module iop_bit_pick #(
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] hit;

  for (genvar g = 0; g < WORD_W; g++) begin : g_lane
    assign hit[g] = word_i[g] && (idx_i == IDX_W'(g));
  end

  assign bit_o = |hit;
endmodule

// File: rtl/iop_ctrl.sv
module iop_ctrl
  import iop_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int WORD_W = 16,
  localparam int IDX_W  = $clog2(WORD_W),
  localparam int ADDR_W = PORT_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_fire_i,
  input  logic              grant_fast_i,
  input  logic              beyond_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              rd_valid_i,
  input  logic              pick_bit_i,
  input  logic              rsp_ready_i,
  output logic              idle_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [IDX_W-1:0]  bit_idx_o,
  output logic              rsp_valid_o,
  output verdict_t          verdict_o
);
  iop_state_e        state_q, state_d;
  logic [PORT_W-1:0] port_q;
  verdict_t          verdict_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_fire_i) state_d = (grant_fast_i || beyond_i) ? ST_RESP : ST_READ;
      ST_READ: state_d = ST_WAIT;
      ST_WAIT: if (rd_valid_i) state_d = ST_RESP;
      ST_RESP: if (rsp_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      port_q    <= '0;
      verdict_q <= '{allow: 1'b0, why: TR_NONE};
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_fire_i) begin
        port_q <= port_i;
        if (grant_fast_i)  verdict_q <= '{allow: 1'b1, why: TR_NONE};
        else if (beyond_i) verdict_q <= '{allow: 1'b0, why: TR_BEYOND};
      end
      if (state_q == ST_WAIT && rd_valid_i) begin
        verdict_q <= pick_bit_i ? '{allow: 1'b1, why: TR_NONE}
                                : '{allow: 1'b0, why: TR_BIT_CLEAR};
      end
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign rd_en_o     = (state_q == ST_READ);
  assign rd_addr_o   = port_q[PORT_W-1:IDX_W];
  assign bit_idx_o   = port_q[IDX_W-1:0];
  assign rsp_valid_o = (state_q == ST_RESP);
  assign verdict_o   = verdict_q;
endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
  import iop_pkg::*;
#(
  parameter int PL_W   = 2,
  parameter int PORT_W = 16,
  parameter int WORD_W = 16,
  localparam int LEN_W  = PORT_W + 1,
  localparam int IDX_W  = $clog2(WORD_W),
  localparam int ADDR_W = PORT_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [PL_W-1:0]   req_cpl_i,
  input  logic [PL_W-1:0]   req_iopl_i,
  input  logic [PORT_W-1:0] req_port_i,
  input  logic [LEN_W-1:0]  req_map_len_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [WORD_W-1:0] mem_rd_data_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_allow_o,
  output logic [1:0]        rsp_reason_o
);
  logic             grant_fast, beyond, pick_bit, idle;
  logic [IDX_W-1:0] bit_idx;
  verdict_t         verdict;

  iop_screen #(.PL_W(PL_W), .PORT_W(PORT_W)) u_screen (
    .cpl_i        (req_cpl_i),
    .iopl_i       (req_iopl_i),
    .port_i       (req_port_i),
    .map_len_i    (req_map_len_i),
    .grant_fast_o (grant_fast),
    .beyond_o     (beyond)
  );

  iop_bit_pick #(.WORD_W(WORD_W)) u_pick (
    .word_i (mem_rd_data_i),
    .idx_i  (bit_idx),
    .bit_o  (pick_bit)
  );

  iop_ctrl #(.PORT_W(PORT_W), .WORD_W(WORD_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_fire_i   (req_valid_i && idle),
    .grant_fast_i (grant_fast),
    .beyond_i     (beyond),
    .port_i       (req_port_i),
    .rd_valid_i   (mem_rd_valid_i),
    .pick_bit_i   (pick_bit),
    .rsp_ready_i  (rsp_ready_i),
    .idle_o       (idle),
    .rd_en_o      (mem_rd_en_o),
    .rd_addr_o    (mem_rd_addr_o),
    .bit_idx_o    (bit_idx),
    .rsp_valid_o  (rsp_valid_o),
    .verdict_o    (verdict)
  );

  assign req_ready_o  = idle;
  assign rsp_allow_o  = verdict.allow;
  assign rsp_reason_o = verdict.why;
endmodule

// File: rtl/iop_check_sva.sv
module iop_check_sva #(
  parameter int PL_W   = 2,
  parameter int PORT_W = 16,
  parameter int WORD_W = 16,
  localparam int LEN_W  = PORT_W + 1,
  localparam int IDX_W  = $clog2(WORD_W),
  localparam int ADDR_W = PORT_W - IDX_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [PL_W-1:0]   req_cpl_i,
  input logic [PL_W-1:0]   req_iopl_i,
  input logic [PORT_W-1:0] req_port_i,
  input logic [LEN_W-1:0]  req_map_len_i,
  input logic              mem_rd_en_o,
  input logic [ADDR_W-1:0] mem_rd_addr_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic              rsp_allow_o,
  input logic [1:0]        rsp_reason_o
);
  logic fire;
  assign fire = req_valid_i && req_ready_o;

  a_r2_fast_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (req_cpl_i <= req_iopl_i) |=> rsp_valid_o && rsp_allow_o && !mem_rd_en_o);

  a_r3_beyond_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (req_cpl_i > req_iopl_i) && ({1'b0, req_port_i} >= req_map_len_i)
    |=> rsp_valid_o && !rsp_allow_o && (rsp_reason_o == 2'd1) && !mem_rd_en_o);

  a_r4_read_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && (req_cpl_i > req_iopl_i) && ({1'b0, req_port_i} < req_map_len_i)
    |=> mem_rd_en_o && (mem_rd_addr_o == $past(req_port_i[PORT_W-1:IDX_W])));

  a_r4_read_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_en_o |=> !mem_rd_en_o);

  a_r6_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !rsp_valid_o && !mem_rd_en_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_allow_o) && $stable(rsp_reason_o));

  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i |=> !rsp_valid_o && req_ready_o);

  a_r8_reason_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_allow_o == (rsp_reason_o == 2'd0)));
endmodule

bind io_perm_check iop_check_sva #(.PL_W(PL_W), .PORT_W(PORT_W), .WORD_W(WORD_W)) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_cpl_i     (req_cpl_i),
  .req_iopl_i    (req_iopl_i),
  .req_port_i    (req_port_i),
  .req_map_len_i (req_map_len_i),
  .mem_rd_en_o   (mem_rd_en_o),
  .mem_rd_addr_o (mem_rd_addr_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_ready_i   (rsp_ready_i),
  .rsp_allow_o   (rsp_allow_o),
  .rsp_reason_o  (rsp_reason_o)
);

// File: tb/test_io_perm_check.sv
module test_io_perm_check;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cpl = '0, req_iopl = '0;
  logic [15:0] req_port = '0;
  logic [16:0] req_len = '0;
  logic        mem_rd_en;
  logic [11:0] mem_rd_addr;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_allow;
  logic [1:0]  rsp_reason;

  int total = 0, fails = 0, rd_cnt = 0;
  int lat = 1, cnt = 0;
  logic pend = 1'b0;
  logic [11:0] pend_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_perm_check i_io_perm_check (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cpl_i(req_cpl), .req_iopl_i(req_iopl),
    .req_port_i(req_port), .req_map_len_i(req_len),
    .mem_rd_en_o(mem_rd_en), .mem_rd_addr_o(mem_rd_addr),
    .mem_rd_valid_i(mem_valid), .mem_rd_data_i(mem_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_allow_o(rsp_allow), .rsp_reason_o(rsp_reason)
  );

  function automatic logic [15:0] map_word(input logic [11:0] a);
    if (a == 12'd0) return 16'h8001;
    return (16'(a) * 16'h9E37) ^ 16'h5A3C;
  endfunction

  // {allow, reason}
  function automatic logic [2:0] expect_of(input logic [1:0] cpl, input logic [1:0] iopl,
                                           input logic [15:0] port, input logic [16:0] len);
    logic [15:0] w;
    if (cpl <= iopl) return 3'b100;
    if ({1'b0, port} >= len) return 3'b001;
    w = map_word(port[15:4]);
    return w[port[3:0]] ? 3'b100 : 3'b010;
  endfunction

  // Bitmap memory model with variable latency
  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mem_rd_en) begin
      rd_cnt <= rd_cnt + 1;
      if (lat == 1) begin
        mem_valid <= 1'b1;
        mem_data  <= map_word(mem_rd_addr);
      end else begin
        pend <= 1'b1; cnt <= lat - 1; pend_addr <= mem_rd_addr;
      end
    end else if (pend) begin
      if (cnt == 1) begin
        mem_valid <= 1'b1;
        mem_data  <= map_word(pend_addr);
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] cpl, input logic [1:0] iopl, input logic [15:0] port,
                         input logic [16:0] len, input int l, input int stall, input bit junk);
    logic [2:0] e;
    int rd0;
    bit lookup;
    e = expect_of(cpl, iopl, port, len);
    lookup = (cpl > iopl) && ({1'b0, port} < len);
    lat = l;
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 idle ready", req_ready, 1);
    rd0 = rd_cnt;
    req_cpl = cpl; req_iopl = iopl; req_port = port; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    if (junk) begin
      req_cpl = 2'd0; req_iopl = 2'd3; req_port = ~port; req_len = 17'd0;
    end else req_valid = 1'b0;
    if (lookup) begin
      chk(mem_rd_en == 1'b1, "R4 read strobe", mem_rd_en, 1);
      chk(mem_rd_addr == port[15:4], "R4 read address", mem_rd_addr, port[15:4]);
      chk(rsp_valid == 1'b0, "R5 no early result", rsp_valid, 0);
      @(negedge clk);
      chk(mem_rd_en == 1'b0, "R4 single strobe", mem_rd_en, 0);
      while (!mem_valid) begin
        chk(rsp_valid == 1'b0 && req_ready == 1'b0, "R5 result before data", rsp_valid, 0);
        @(negedge clk);
      end
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R5 result after data", rsp_valid, 1);
      chk(rd_cnt == rd0 + 1, "R4 one read", rd_cnt - rd0, 1);
    end else begin
      chk(rsp_valid == 1'b1, (cpl <= iopl) ? "R2 fast result" : "R3 beyond result", rsp_valid, 1);
      chk(rd_cnt == rd0, (cpl <= iopl) ? "R2 no read" : "R3 no read", rd_cnt - rd0, 0);
    end
    chk(req_ready == 1'b0, "R6 busy not ready", req_ready, 0);
    chk({rsp_allow, rsp_reason} == e,
        lookup ? "R5 verdict" : ((cpl <= iopl) ? "R2 verdict" : "R3 verdict"),
        {rsp_allow, rsp_reason}, e);
    chk(rsp_allow == (rsp_reason == 2'd0), "R8 reason vs allow", {rsp_allow, rsp_reason}, e);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rsp_valid && {rsp_allow, rsp_reason} == e, "R7 hold", {rsp_valid, rsp_allow, rsp_reason}, {1'b1, e});
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R7 release", {rsp_valid, req_ready}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7);
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_en == 1'b0, "R1 in reset",
        {req_ready, rsp_valid, mem_rd_en}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_en == 1'b0, "R1 after reset",
        {req_ready, rsp_valid, mem_rd_en}, 3'b100);

    run_req(2'd2, 2'd2, 16'h0001, 17'd0, 1, 0, 0);       // R2 equal levels
    run_req(2'd0, 2'd3, 16'hFFFF, 17'd0, 1, 2, 0);       // R2 beyond bitmap but granted
    run_req(2'd3, 2'd0, 16'h0000, 17'd0, 1, 0, 0);       // R3 empty bitmap
    run_req(2'd3, 2'd2, 16'h0010, 17'd16, 1, 1, 0);      // R3 port equals length
    run_req(2'd1, 2'd0, 16'h0000, 17'd1, 1, 0, 0);       // R5 bit 0 set
    run_req(2'd1, 2'd0, 16'h0001, 17'd16, 2, 0, 1);      // R5 bit clear, R6 junk while busy
    run_req(2'd3, 2'd1, 16'h000F, 17'd16, 4, 3, 1);      // R5 bit 15, last port in map
    run_req(2'd3, 2'd0, 16'hFFFF, 17'h10000, 3, 0, 0);   // R5 full-length map, top port

    for (int i = 0; i < 300; i++) begin
      logic [15:0] p;
      logic [16:0] len;
      p = 16'($urandom);
      case ($urandom_range(0, 3))
        0: len = 17'($urandom_range(0, 65536));
        1: len = {1'b0, p};
        2: len = {1'b0, p} + 17'd1;
        default: len = 17'h10000;
      endcase
      run_req(2'($urandom), 2'($urandom), p, len, $urandom_range(1, 4),
              $urandom_range(0, 2), 1'($urandom));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule